// File: doc/BRIEF.md
# Miss-Triggered Flash Line Read Buffer

This block sits between a simple word-read port and a serial-flash sequence engine. It holds one 128-byte line of flash contents, with a tag and a valid flag. A read whose word lies in the held line is answered in the same cycle. Any other read clears the line and pulses a start request to the engine. The request carries the line-aligned byte address and the sequence index taken from a configuration input. The engine then streams the line back one byte per beat, in address order.

The requesting master holds its request until the ready output is high. A word becomes available as soon as its four bytes have arrived, so the first word of a line can return long before the line is complete. Words come back in little-endian order. After software has programmed or erased the flash, it pulses the invalidate input so that stale contents are never served. An invalidate that arrives during a fill discards that fill. The block does not look at any master identifier, and every requester shares the one line.

Top module: `flash_line_buffer`

## Requirements
- R1: After reset the line is empty: `rd_ready` and `seq_start` are low, and the first read of any address misses.
- R2: A read of a word in the valid held line raises `rd_ready` in the same cycle as the request. It produces no `seq_start` pulse.
- R3: A read that misses while no fill is running causes a one-cycle `seq_start` pulse in the next cycle. `seq_addr` is the byte address of the word with its low 7 bits cleared. `seq_idx` equals `cfg_seq_idx` as sampled in the miss cycle.
- R4: During a fill, each cycle with `fill_valid` high stores `fill_byte` at the next line offset, starting from 0. After the 128th byte the line is valid and later reads in it hit.
- R5: `rd_data` is little-endian. The byte at line offset 4k+j sits in bits 8j+7:8j of word k, where word k is `rd_word_addr[4:0]`.
- R6: A missing read is stalled with `rd_ready` low only until the four bytes of its own word have arrived. That can be before the fill completes.
- R7: A read of a different line during a fill waits until the fill ends. It then misses and starts a new sequence. No second start is issued while a fill is running.
- R8: A one-cycle `inval` pulse clears the valid flag, and the next read of the previously held line misses and refetches.
- R9: An `inval` pulse during a fill discards that fill. No request is served from it, and a pending or later read of that line starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_word_addr | input | ADDR_W-2 | Word address of the read (byte address / 4) |
| rd_ready | output | 1 | Read data valid this cycle; request completes |
| rd_data | output | 32 | Little-endian read word |
| inval | input | 1 | Discard buffered contents |
| cfg_seq_idx | input | SEQ_W | Sequence index used for line fetches |
| seq_start | output | 1 | One-cycle request to the sequence engine |
| seq_idx | output | SEQ_W | Sequence index for the started fetch |
| seq_addr | output | ADDR_W | Line-aligned byte address of the fetch |
| fill_valid | input | 1 | Fill byte present this cycle |
| fill_byte | input | 8 | Next byte of the line being fetched |

## Verification
The hardest situation to reach from the ports is an invalidate that lands in the middle of a fill while a read of the same line is waiting. That read must not be served from the partial line, and it must trigger a second fetch once the discarded stream has drained. The stimulus first completes an early read of word 0 of a fresh line, which proves the engine is still streaming. It then pulses `inval` with the engine still busy and issues a read of a later word in that line. The bench counts sequence starts and compares the returned word against an independent flash model. A read to a different line issued right after an early return exercises the wait-then-miss ordering in the same way.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fill_state_t;
endpackage

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int TAG_W      = 17,
  parameter int OFF_W      = 7,
  parameter int SEQ_W      = 4,
  parameter int LINE_BYTES = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [OFF_W-3:0]    req_word,
  input  logic                inval,
  input  logic [SEQ_W-1:0]    cfg_seq_idx,
  input  logic                fill_valid,
  output logic                serve,
  output logic                fill_we,
  output logic [OFF_W-1:0]    fill_off,
  output logic                seq_start,
  output logic [SEQ_W-1:0]    seq_idx,
  output logic [TAG_W-1:0]    seq_tag
);
  localparam int CNT_W = OFF_W + 1;

  fill_state_t       state;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [CNT_W-1:0]  fill_ptr;
  logic [OFF_W-2:0]  words_done;
  logic              tag_match;
  logic              miss;
  logic              last_byte;

  assign words_done = fill_ptr[CNT_W-1:2];
  assign tag_match  = (line_tag == req_tag);
  assign serve      = rd_req && tag_match &&
                      (line_valid || (state == FS_FILL && {1'b0, req_word} < words_done));
  assign miss       = rd_req && !serve && (state == FS_IDLE);
  assign fill_we    = fill_valid && (state != FS_IDLE);
  assign fill_off   = fill_ptr[OFF_W-1:0];
  assign last_byte  = fill_we && (fill_ptr == CNT_W'(LINE_BYTES - 1));
  assign seq_tag    = line_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FS_IDLE;
      line_valid <= 1'b0;
      line_tag   <= '0;
      fill_ptr   <= '0;
      seq_start  <= 1'b0;
      seq_idx    <= '0;
    end else begin
      seq_start <= miss;
      if (miss) begin
        line_tag   <= req_tag;
        line_valid <= 1'b0;
        state      <= FS_FILL;
        fill_ptr   <= '0;
        seq_idx    <= cfg_seq_idx;
      end else if (last_byte) begin
        state      <= FS_IDLE;
        fill_ptr   <= '0;
        line_valid <= (state == FS_FILL) && !inval;
      end else begin
        if (fill_we) fill_ptr <= fill_ptr + 1'b1;
        if (inval && state == FS_FILL) state <= FS_DROP;
        if (inval) line_valid <= 1'b0;
      end
    end
  end

  // R3
  seq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  // R3
  seq_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> seq_idx == $past(cfg_seq_idx));
  // R7
  fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != FS_IDLE) |=> !seq_start);
  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !last_byte) |=> !line_valid);
  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> $past(last_byte));
  // R9
  drop_no_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_DROP) |-> !serve);
endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
  parameter int OFF_W      = 7,
  parameter int LINE_BYTES = 128
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-3:0] rd_word,
  output logic [31:0]      rd_data
);
  logic [7:0] mem [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[wr_off] <= wr_byte;
  end

  for (genvar j = 0; j < 4; j++) begin : g_lane
    assign rd_data[8*j +: 8] = mem[{rd_word, 2'(j)}];
  end
endmodule

// File: rtl/flash_line_buffer.sv
module flash_line_buffer #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 128,
  parameter int SEQ_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-3:0] rd_word_addr,
  output logic              rd_ready,
  output logic [31:0]       rd_data,
  input  logic              inval,
  input  logic [SEQ_W-1:0]  cfg_seq_idx,
  output logic              seq_start,
  output logic [SEQ_W-1:0]  seq_idx,
  output logic [ADDR_W-1:0] seq_addr,
  input  logic              fill_valid,
  input  logic [7:0]        fill_byte
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WIDX_W = OFF_W - 2;
  localparam int WA_W   = ADDR_W - 2;
  localparam int TAG_W  = ADDR_W - OFF_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [WA_W-1:0] wa);
    return wa[WA_W-1:WIDX_W];
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [WA_W-1:0] wa);
    return wa[WIDX_W-1:0];
  endfunction

  logic              fill_we;
  logic [OFF_W-1:0]  fill_off;
  logic [TAG_W-1:0]  seq_tag;

  lbuf_ctrl #(
    .TAG_W(TAG_W), .OFF_W(OFF_W), .SEQ_W(SEQ_W), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .req_tag(tag_of(rd_word_addr)), .req_word(word_of(rd_word_addr)),
    .inval(inval), .cfg_seq_idx(cfg_seq_idx), .fill_valid(fill_valid),
    .serve(rd_ready), .fill_we(fill_we), .fill_off(fill_off),
    .seq_start(seq_start), .seq_idx(seq_idx), .seq_tag(seq_tag)
  );

  lbuf_store #(.OFF_W(OFF_W), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .we(fill_we), .wr_off(fill_off), .wr_byte(fill_byte),
    .rd_word(word_of(rd_word_addr)), .rd_data(rd_data)
  );

  assign seq_addr = {seq_tag, {OFF_W{1'b0}}};

  // R2
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_req);
  // R3
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_start && !$past(rd_req)) |-> $stable(seq_addr));
endmodule

// File: tb/flash_line_buffer_test.sv
`timescale 1ns/1ps
module flash_line_buffer_test;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0;
  logic [ADDR_W-3:0] rd_word_addr = '0;
  logic rd_ready;
  logic [31:0] rd_data;
  logic inval = 1'b0;
  logic [3:0] cfg_seq_idx = 4'd5;
  logic seq_start;
  logic [3:0] seq_idx;
  logic [ADDR_W-1:0] seq_addr;
  logic fill_valid = 1'b0;
  logic [7:0] fill_byte = '0;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  bit eng_busy = 1'b0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [3:0] last_idx = '0;

  always #10 clk = ~clk;

  flash_line_buffer uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_word_addr(rd_word_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .inval(inval),
    .cfg_seq_idx(cfg_seq_idx), .seq_start(seq_start), .seq_idx(seq_idx),
    .seq_addr(seq_addr), .fill_valid(fill_valid), .fill_byte(fill_byte)
  );

  function automatic logic [7:0] fl(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ (a[23:16] + 8'hA5);
  endfunction

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] b;
    b = {a[ADDR_W-1:2], 2'b00};
    return {fl(b + 3), fl(b + 2), fl(b + 1), fl(b)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash engine model
  initial begin
    forever begin
      @(negedge clk);
      if (seq_start) begin
        starts++;
        last_addr = seq_addr;
        last_idx = seq_idx;
        eng_busy = 1'b1;
        for (int i = 0; i < 128; i++) begin
          fill_valid = 1'b1;
          fill_byte = fl(seq_addr + ADDR_W'(i));
          @(negedge clk);
        end
        fill_valid = 1'b0;
        eng_busy = 1'b0;
      end
    end
  end

  // called at a negedge; returns at a negedge with the request dropped
  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                    output bit stalled, output bit busy_at);
    int cyc;
    cyc = 0;
    rd_req = 1'b1;
    rd_word_addr = a[ADDR_W-1:2];
    d = '0;
    busy_at = 1'b0;
    forever begin
      #1;
      if (rd_ready) begin
        d = rd_data;
        busy_at = eng_busy;
        break;
      end
      cyc++;
      if (cyc > 1000) begin
        chk(1'b0, "watchdog read", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    stalled = (cyc > 0);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse_inval();
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  localparam logic [24:0] VEC [8] = '{
    {1'b1, 24'h000100}, {1'b0, 24'h000104}, {1'b0, 24'h00017C},
    {1'b0, 24'h000140}, {1'b1, 24'h000180}, {1'b1, 24'h000100},
    {1'b1, 24'h00FFFC}, {1'b0, 24'h00FF80}
  };

  initial begin
    #4000000;
    chk(1'b0, "watchdog global", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit st, bz;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_ready == 1'b0, "R1 rd_ready after reset", rd_ready, 0);
    chk(seq_start == 1'b0, "R1 seq_start after reset", seq_start, 0);

    for (int i = 0; i < 8; i++) begin
      logic [ADDR_W-1:0] a;
      bit m;
      a = VEC[i][23:0];
      m = VEC[i][24];
      s0 = starts;
      rd(a, d, st, bz);
      repeat (140) @(negedge clk);
      chk(d == exp_word(a), "R5 vector data", d, exp_word(a));
      chk((starts - s0) == int'(m), "R2/R3 vector miss count", starts - s0, int'(m));
      chk(st == m, "R2 vector stall", st, m);
      if (m) begin
        chk(last_addr == {a[23:7], 7'd0}, "R3 seq_addr aligned", last_addr, {a[23:7], 7'd0});
        chk(last_idx == 4'd5, "R3 seq_idx", last_idx, 5);
      end
    end

    // R6 early word return, then same-line word waits for its bytes
    s0 = starts;
    rd(24'h002000, d, st, bz);
    chk(bz == 1'b1, "R6 word 0 returned during fill", bz, 1);
    chk(d == exp_word(24'h002000), "R6 early data", d, exp_word(24'h002000));
    rd(24'h00207C, d, st, bz);
    chk(d == exp_word(24'h00207C), "R4 last word data", d, exp_word(24'h00207C));
    chk(starts - s0 == 1, "R4 no extra start same line", starts - s0, 1);
    @(negedge clk);
    rd(24'h002040, d, st, bz);
    chk(st == 1'b0 && starts - s0 == 1, "R4 line valid after fill", st, 0);

    // R7 other line during fill
    s0 = starts;
    rd(24'h003000, d, st, bz);
    chk(bz == 1'b1, "R7 fill running", bz, 1);
    rd(24'h004010, d, st, bz);
    chk(d == exp_word(24'h004010), "R7 data other line", d, exp_word(24'h004010));
    chk(starts - s0 == 2, "R7 two starts", starts - s0, 2);
    chk(last_addr == 24'h004000, "R7 second fetch address", last_addr, 24'h004000);
    repeat (140) @(negedge clk);

    // R8 invalidate
    s0 = starts;
    rd(24'h004010, d, st, bz);
    chk(st == 1'b0 && starts == s0, "R8 hit before inval", starts - s0, 0);
    pulse_inval();
    rd(24'h004010, d, st, bz);
    chk(starts - s0 == 1, "R8 miss after inval", starts - s0, 1);
    chk(d == exp_word(24'h004010), "R8 data after refetch", d, exp_word(24'h004010));
    repeat (140) @(negedge clk);

    // R9 invalidate during fill
    cfg_seq_idx = 4'd9;
    s0 = starts;
    rd(24'h005000, d, st, bz);
    chk(eng_busy == 1'b1, "R9 engine busy at inval", eng_busy, 1);
    pulse_inval();
    rd(24'h005004, d, st, bz);
    chk(starts - s0 == 2, "R9 refetch after dropped fill", starts - s0, 2);
    chk(d == exp_word(24'h005004), "R9 data", d, exp_word(24'h005004));
    chk(last_idx == 4'd9, "R3 seq_idx changed cfg", last_idx, 9);
    repeat (140) @(negedge clk);
    rd(24'h005008, d, st, bz);
    chk(st == 1'b0 && starts - s0 == 2, "R9 line valid after refetch", st, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule